// File: doc/BRIEF.md
# Secret Storage Command Controller

This block keeps a 64-bit authentication secret together with a write-protect flag. A host sends it single-byte management commands. The block can zero the secret, make it permanently read-only, or ask an external hash engine to derive a new value. The derivation comes in two flavours: one mixes in the device's ROM identifier to give a per-device secret, and the other leaves it out to give a shared secret.

Every change that would be persistent opens a timed write window. The window models the nonvolatile programming time. The busy output stays high during the window, and the host polls busy to learn when the change is committed. Commands that arrive while busy is high are dropped.

Once the protect flag is set, every command that would change the secret is refused. A refused command leaves the secret as it is and produces a short pulse. The reset values of the secret and the flag are parameters, and they stand in for contents already held in nonvolatile storage.

Top module: `secret_cmd_ctrl`

## Requirements
- R1: After reset, `secret` equals INIT_SECRET, `locked` equals INIT_LOCKED, and `busy`, `hash_start`, `rejected` and `illegal` are all low.
- R2: When unlocked, command byte 8'h5A sets `secret` to all zeros and opens a write window.
- R3: When unlocked, command byte 8'h30 raises `hash_start` for exactly one cycle with `hash_with_rom` = 0. `hash_with_rom` holds that value until `hash_done`. On `hash_done`, `secret` takes `hash_result` and a write window opens.
- R4: When unlocked, command byte 8'h33 behaves as R3, except that `hash_with_rom` = 1.
- R5: Command byte 8'h60 sets `locked` and opens a write window. No command ever clears `locked`. When `locked` is already set, 8'h60 has no effect and produces no pulse and no write window.
- R6: While `locked` is set, command bytes 8'h5A, 8'h30 and 8'h33 leave `secret` unchanged and do not raise `hash_start`. Each one raises `rejected` for exactly one cycle, in the cycle after the command.
- R7: A write window keeps `busy` high for exactly NV_WRITE_CYCLES cycles. For 8'h5A and 8'h60 the window begins in the cycle after the command. For generation commands it begins in the cycle after `hash_done`. `busy` is also high while a hash result is awaited.
- R8: A command presented while `busy` is high is ignored. It changes neither the secret nor the flag, and it raises neither `rejected` nor `illegal`.
- R9: Any command byte other than 8'h5A, 8'h30, 8'h33 or 8'h60, presented while idle, raises `illegal` for one cycle in the cycle after the command and changes nothing else.
- R10: `hash_done` is ignored unless a generation request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is presented this cycle |
| cmd_byte | input | 8 | Command code |
| hash_done | input | 1 | Hash engine result is ready |
| hash_result | input | 64 | Value derived by the hash engine |
| hash_start | output | 1 | One-cycle request to the hash engine |
| hash_with_rom | output | 1 | Request mode: 1 includes the ROM identifier |
| secret | output | 64 | Current stored secret |
| locked | output | 1 | Write-protect flag |
| busy | output | 1 | Command in progress or write window open |
| rejected | output | 1 | One-cycle pulse: command refused because locked |
| illegal | output | 1 | One-cycle pulse: unknown command byte |

## Verification
Several behaviours are checked by assertions on every cycle. The protect flag never falls. The secret is frozen while locked. The hash request is a single-cycle pulse that never fires while locked. The refusal and unknown-command pulses are never exclusive of each other being absent, never occur together, and only follow a cycle in which the block was idle.

Other behaviours can only be shown by the bench's scenarios. These are the exact length of each write window, the value loaded from the hash engine, the mode bit for each generation command, and the loss of commands sent while busy. The bench also covers stray completion signals, and it shows that a repeated lock command leaves no trace.

// File: rtl/secret_cmd_ctrl.sv
module secret_cmd_ctrl #(
  parameter int unsigned          SECRET_W        = 64,
  parameter int unsigned          NV_WRITE_CYCLES = 1000,
  parameter logic                 INIT_LOCKED     = 1'b0,
  parameter logic [SECRET_W-1:0]  INIT_SECRET     = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_byte,
  input  logic                hash_done,
  input  logic [SECRET_W-1:0] hash_result,
  output logic                hash_start,
  output logic                hash_with_rom,
  output logic [SECRET_W-1:0] secret,
  output logic                locked,
  output logic                busy,
  output logic                rejected,
  output logic                illegal
);

  localparam int unsigned CW = $clog2(NV_WRITE_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(NV_WRITE_CYCLES - 1);

  localparam logic [7:0] OP_CLEAR  = 8'h5A;
  localparam logic [7:0] OP_GEN_GL = 8'h30;
  localparam logic [7:0] OP_GEN_ID = 8'h33;
  localparam logic [7:0] OP_LOCK   = 8'h60;

  typedef enum logic [1:0] {ST_IDLE, ST_HASH, ST_WRITE} state_t;

  state_t        state;
  logic [CW-1:0] win_cnt;

  wire take = cmd_valid && (state == ST_IDLE);
  wire is_gen = (cmd_byte == OP_GEN_GL) || (cmd_byte == OP_GEN_ID);

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      win_cnt       <= '0;
      secret        <= INIT_SECRET;
      locked        <= INIT_LOCKED;
      hash_start    <= 1'b0;
      hash_with_rom <= 1'b0;
      rejected      <= 1'b0;
      illegal       <= 1'b0;
    end else begin
      hash_start <= 1'b0;
      rejected   <= 1'b0;
      illegal    <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          if (cmd_byte == OP_CLEAR) begin
            if (locked) rejected <= 1'b1;
            else begin
              secret  <= '0;
              state   <= ST_WRITE;
              win_cnt <= WIN_LAST;
            end
          end else if (is_gen) begin
            if (locked) rejected <= 1'b1;
            else begin
              hash_start    <= 1'b1;
              hash_with_rom <= (cmd_byte == OP_GEN_ID);
              state         <= ST_HASH;
            end
          end else if (cmd_byte == OP_LOCK) begin
            if (!locked) begin
              locked  <= 1'b1;
              state   <= ST_WRITE;
              win_cnt <= WIN_LAST;
            end
          end else begin
            illegal <= 1'b1;
          end
        end
        ST_HASH: if (hash_done) begin
          secret  <= hash_result;
          state   <= ST_WRITE;
          win_cnt <= WIN_LAST;
        end
        ST_WRITE: begin
          if (win_cnt == '0) state <= ST_IDLE;
          else win_cnt <= win_cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_secret_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(secret));

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start);

  p_start_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |-> (!locked && busy));

  p_reject_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> (locked && !busy));

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rejected && illegal));

  p_pulse_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected || illegal) |-> !$past(busy));

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(secret) && $stable(locked) && !busy));

endmodule

// File: tb/secret_cmd_ctrl_tb.sv
module secret_cmd_ctrl_tb;

  localparam int unsigned NV = 16;
  localparam logic [63:0] INIT_S = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic        hash_done = 1'b0;
  logic [63:0] hash_result = '0;
  logic        hash_start, hash_with_rom, locked, busy, rejected, illegal;
  logic [63:0] secret;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  secret_cmd_ctrl #(.SECRET_W(64), .NV_WRITE_CYCLES(NV),
                    .INIT_LOCKED(1'b0), .INIT_SECRET(INIT_S)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .hash_done(hash_done), .hash_result(hash_result),
    .hash_start(hash_start), .hash_with_rom(hash_with_rom),
    .secret(secret), .locked(locked), .busy(busy),
    .rejected(rejected), .illegal(illegal));

  typedef struct packed {
    logic [7:0]  cmd;
    logic [63:0] res;
    logic [63:0] sec;
    logic        lk;
    logic        rej;
    logic        ill;
    logic        hs;
    logic        rom;
    logic [15:0] wr;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{8'h5A, 64'h0,                   64'h0,                   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'(NV)},
    '{8'h30, 64'hAAAA_5555_1234_0001, 64'hAAAA_5555_1234_0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'(NV)},
    '{8'h33, 64'hBEEF_0000_CAFE_0002, 64'hBEEF_0000_CAFE_0002, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'(NV)},
    '{8'h77, 64'h0,                   64'hBEEF_0000_CAFE_0002, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0},
    '{8'h5A, 64'h0,                   64'h0,                   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'(NV)},
    '{8'h33, 64'hC0C0_1111_2222_0003, 64'hC0C0_1111_2222_0003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'(NV)},
    '{8'h60, 64'h0,                   64'hC0C0_1111_2222_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'(NV)},
    '{8'h5A, 64'h0,                   64'hC0C0_1111_2222_0003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
    '{8'h30, 64'h0,                   64'hC0C0_1111_2222_0003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
    '{8'h33, 64'h0,                   64'hC0C0_1111_2222_0003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
    '{8'h60, 64'h0,                   64'hC0C0_1111_2222_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
    '{8'h00, 64'h0,                   64'hC0C0_1111_2222_0003, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "secret", secret, INIT_S);
    chk("R1", "locked", 64'(locked), 64'h0);
    chk("R1", "busy/pulses", {60'h0, busy, hash_start, rejected, illegal}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {62'h0, busy, hash_start}, 64'h0);

    // R10: completion with nothing pending
    hash_done = 1'b1;
    hash_result = 64'hDEAD_DEAD_DEAD_DEAD;
    @(negedge clk);
    hash_done = 1'b0;
    @(negedge clk);
    chk("R10", "stray hash_done secret", secret, INIT_S);
    chk("R10", "stray hash_done busy", 64'(busy), 64'h0);

    foreach (VECS[i]) begin
      send(VECS[i].cmd);
      chk(VECS[i].rej ? "R6" : "R5", $sformatf("vec %0d rejected", i), 64'(rejected), 64'(VECS[i].rej));
      chk("R9", $sformatf("vec %0d illegal", i), 64'(illegal), 64'(VECS[i].ill));
      chk(VECS[i].rom ? "R4" : "R3", $sformatf("vec %0d hash_start", i), 64'(hash_start), 64'(VECS[i].hs));
      if (VECS[i].hs) begin
        chk(VECS[i].rom ? "R4" : "R3", $sformatf("vec %0d mode", i), 64'(hash_with_rom), 64'(VECS[i].rom));
        @(negedge clk);
        chk("R3", $sformatf("vec %0d start single", i), 64'(hash_start), 64'h0);
        chk("R7", $sformatf("vec %0d busy in wait", i), 64'(busy), 64'h1);
        @(negedge clk);
        hash_done = 1'b1;
        hash_result = VECS[i].res;
        @(negedge clk);
        hash_done = 1'b0;
      end
      count_busy(n);
      chk("R7", $sformatf("vec %0d window", i), 64'(n), 64'(VECS[i].wr));
      chk(VECS[i].cmd == 8'h5A ? "R2" : "R6", $sformatf("vec %0d secret", i), secret, VECS[i].sec);
      chk("R5", $sformatf("vec %0d locked", i), 64'(locked), 64'(VECS[i].lk));
      @(negedge clk);
    end

    // R8: commands while busy, after a reset to the unlocked preload
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "re-reset locked", 64'(locked), 64'h0);
    send(8'h30);
    chk("R3", "start for busy test", 64'(hash_start), 64'h1);
    cmd_valid = 1'b1;
    cmd_byte = 8'h5A;
    @(negedge clk);
    cmd_byte = 8'h77;
    @(negedge clk);
    chk("R8", "no pulse in hash wait", {62'h0, rejected, illegal}, 64'h0);
    cmd_valid = 1'b0;
    hash_done = 1'b1;
    hash_result = 64'h5151_A0A0_7E7E_0009;
    @(negedge clk);
    hash_done = 1'b0;
    chk("R8", "illegal ignored while busy", 64'(illegal), 64'h0);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte = 8'h5A;
    @(negedge clk);
    cmd_byte = 8'h60;
    @(negedge clk);
    cmd_valid = 1'b0;
    count_busy(n);
    chk("R7", "window with ignored commands", 64'(n + 5), 64'(NV));
    chk("R8", "clear ignored in window", secret, 64'h5151_A0A0_7E7E_0009);
    chk("R8", "lock ignored in window", 64'(locked), 64'h0);

    finish_run();
  end

endmodule